// File: doc/BRIEF.md
# Phase Build-Out Reference Generator

This block sits between the reference selector and the phase detector of a digital PLL. It runs on a fast sampling clock and receives one-cycle edge strobes for the incoming reference and for the PLL feedback. From these it measures the reference-to-feedback phase offset in sampling-clock counts. The measurement wraps modulo one reference period into a signed range.

When a mode change or reference switch is signalled, the current measurement is latched into a build-out register. Every later reference edge is then re-timed by that amount. The phase detector receives a virtual reference with the same phase as before the switch, so the output sees no phase step.

When build-out is disabled, the stored offset is not dropped at once. It is walked toward zero by one count per slew frame, which limits the rate of phase change at the output. A filtered active-low clear zeroes the stored offset. A holdover-return input lets the control logic veto the automatic enable.

Top module: `pbo_refgen`

## Requirements
- R1: The effective enable `build_en_o` equals `en_pin | (auto_en & ~hold_ret)`, combinationally.
- R2: The measured difference is the number of sampling-clock edges from the edge that samples `ref_stb` to the edge that samples `fb_stb`, taken modulo `PERIOD_CNT`. A value above `PERIOD_CNT/2` is reported as that value minus `PERIOD_CNT`. Strobes on the same edge measure 0.
- R3: A `mode_stb` sampled while the block is enabled loads the latest measurement into the stored offset. The stored offset appears on `offset_o` as 16-bit two's complement on the following cycle.
- R4: A `mode_stb` sampled while the block is disabled leaves `offset_o` unchanged. This includes the case where auto-enable is vetoed by `hold_ret`.
- R5: For a stored offset D >= 0, `vref_stb` is high for one cycle after the D-th clock edge following the edge that samples `ref_stb`. For D = 0, that is the same edge.
- R6: For a negative stored offset D, the delay is D + `PERIOD_CNT` edges.
- R7: `clr_n` low for `CLR_LOW_MIN` consecutive samples zeroes `offset_o` on the next edge. A low run one sample shorter leaves it unchanged.
- R8: While the clear is in effect, a `mode_stb` is overridden and `offset_o` stays 0.
- R9: While disabled, `offset_o` moves one count toward zero every `FRAME_CNT` cycles. The first step lands on the `FRAME_CNT`-th edge after the disable is sampled, and the offset stays at 0 once it reaches 0.
- R10: While enabled and without capture or clear, `offset_o` holds its value indefinitely.
- R11: After reset, `offset_o` is 0, `vref_stb` is 0 and, with all enables low, `build_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe per reference edge |
| fb_stb | input | 1 | One-cycle strobe per feedback edge |
| en_pin | input | 1 | Manual build-out enable |
| auto_en | input | 1 | Automatic enable from state control |
| hold_ret | input | 1 | Holdover-return veto of automatic enable |
| mode_stb | input | 1 | One-cycle mode change / switch strobe |
| clr_n | input | 1 | Active-low clear of the stored offset (filtered) |
| vref_stb | output | 1 | One-cycle virtual reference strobe |
| offset_o | output | 16 | Stored phase offset, signed sampling-clock counts |
| build_en_o | output | 1 | Effective build-out enable |

## Verification
A capture strobe and an active clear can land on the same edge. The clear then has to win, or a stale measurement would survive a clear request. The bench holds `clr_n` low well past the filter length and pulses `mode_stb` in the middle of that run, while a nonzero measurement is pending. It then expects `offset_o` to read 0 after release, and checks that a fresh capture after the clear loads the pending value.

// File: rtl/pbo_pkg.sv
// Package: shared width and offset type for the phase build-out generator.
// Assumes offsets fit a 16-bit signed count of sampling-clock periods.
package pbo_pkg;
    localparam int OFF_W = 16;
    typedef logic signed [OFF_W-1:0] pbo_off_t;
endpackage

// File: rtl/pbo_phase_meter.sv
// Measures cycles from each reference strobe to the next feedback strobe.
// The result wraps modulo PERIOD_CNT into a signed range centred on zero.
// Assumes PERIOD_CNT >= 2 and PERIOD_CNT/2 fits in a pbo_off_t.
module pbo_phase_meter
    import pbo_pkg::*;
#(
    parameter int PERIOD_CNT = 12500
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ref_stb,
    input  logic     fb_stb,
    output pbo_off_t meas_o
);
    localparam int PH_W = $clog2(PERIOD_CNT + 1);
    localparam int HALF = PERIOD_CNT / 2;

    logic [PH_W-1:0] ph_q;
    pbo_off_t        diff;
    pbo_off_t        meas_q;

    // Phase counter: cycles elapsed since the last reference strobe, modulo the period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= '0;
        else if (ref_stb)
            ph_q <= PH_W'(1);
        else if (ph_q == PH_W'(PERIOD_CNT - 1))
            ph_q <= '0;
        else
            ph_q <= ph_q + PH_W'(1);
    end

    // Map the raw count into the signed window; coincident strobes read zero.
    always_comb begin
        if (ref_stb)
            diff = '0;
        else if (int'(ph_q) > HALF)
            diff = pbo_off_t'(int'(ph_q) - PERIOD_CNT);
        else
            diff = pbo_off_t'(int'(ph_q));
    end

    // Latch the difference on each feedback strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            meas_q <= '0;
        else if (fb_stb)
            meas_q <= diff;
    end

    assign meas_o = meas_q;

    // R2
    meas_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(meas_q) >= -HALF) && (int'(meas_q) <= HALF));
endmodule

// File: rtl/pbo_clear_filter.sv
// Qualifies the active-low clear: it acts only after CLR_LOW_MIN consecutive
// low samples, so short glitches are ignored. Assumes CLR_LOW_MIN >= 1.
module pbo_clear_filter #(
    parameter int CLR_LOW_MIN = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic clr_hit_o
);
    localparam int CW = $clog2(CLR_LOW_MIN + 1);

    logic [CW-1:0] low_q;

    // Count consecutive low samples, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_q <= '0;
        else if (clr_n)
            low_q <= '0;
        else if (low_q != CW'(CLR_LOW_MIN))
            low_q <= low_q + CW'(1);
    end

    assign clr_hit_o = (low_q == CW'(CLR_LOW_MIN));

    // R7
    clr_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit_o |-> !$past(clr_n));
endmodule

// File: rtl/pbo_offset_store.sv
// Holds the build-out offset. Enabled: it captures on mode strobes, otherwise holds.
// Disabled: it slews one count toward zero per FRAME_CNT cycles.
// A qualified clear overrides everything. Assumes FRAME_CNT >= 2.
module pbo_offset_store
    import pbo_pkg::*;
#(
    parameter int FRAME_CNT = 12500
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_eff,
    input  logic     mode_stb,
    input  logic     clr_hit,
    input  pbo_off_t meas_i,
    output pbo_off_t applied_o
);
    localparam int FW = $clog2(FRAME_CNT);

    logic [FW-1:0] fcnt_q;
    pbo_off_t      applied_q;
    logic          slew_tick;

    assign slew_tick = !en_eff && (applied_q != '0) && (fcnt_q == FW'(FRAME_CNT - 1));

    // Slew frame timer: runs only while disabled with a nonzero offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fcnt_q <= '0;
        else if (en_eff || (applied_q == '0) || slew_tick)
            fcnt_q <= '0;
        else
            fcnt_q <= fcnt_q + FW'(1);
    end

    // Offset register: clear, then capture, then slew step, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)
            applied_q <= '0;
        else if (clr_hit)
            applied_q <= '0;
        else if (en_eff && mode_stb)
            applied_q <= meas_i;
        else if (slew_tick) begin
            if (applied_q[OFF_W-1])
                applied_q <= applied_q + 16'sd1;
            else
                applied_q <= applied_q - 16'sd1;
        end
    end

    assign applied_o = applied_q;

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && mode_stb && !clr_hit) |=> (applied_q == $past(meas_i)));
    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (applied_q == '0));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && !mode_stb && !clr_hit) |=> $stable(applied_q));
    // R9
    slew_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_eff && !clr_hit) |=> ((applied_q == $past(applied_q)) ||
                                   (applied_q == $past(applied_q) + 16'sd1) ||
                                   (applied_q == $past(applied_q) - 16'sd1)));
    // R9
    slew_dir_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_eff && !clr_hit && (applied_q > 16'sd0)) |=> (applied_q >= 16'sd0));
    // R9
    slew_dir_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_eff && !clr_hit && (applied_q < 16'sd0)) |=> (applied_q <= 16'sd0));
endmodule

// File: rtl/pbo_retimer.sv
// Emits the virtual reference: a one-cycle pulse a number of edges after each
// reference strobe. That number is the stored offset, with a negative offset
// first raised by one period. Assumes reference strobes arrive at most once
// per period.
module pbo_retimer
    import pbo_pkg::*;
#(
    parameter int PERIOD_CNT = 12500
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ref_stb,
    input  pbo_off_t applied_i,
    output logic     vref_o
);
    localparam int PH_W = $clog2(PERIOD_CNT + 1);

    logic [PH_W-1:0] dly;
    logic [PH_W-1:0] cnt_q;
    logic            busy_q;
    logic            vref_q;

    // Convert the signed offset into a non-negative delay within one period.
    always_comb begin
        if (applied_i[OFF_W-1])
            dly = PH_W'(int'(applied_i) + PERIOD_CNT);
        else
            dly = PH_W'(int'(applied_i));
    end

    // Countdown from each reference strobe; fire the pulse when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            vref_q <= 1'b0;
        end else begin
            vref_q <= 1'b0;
            if (ref_stb) begin
                if (dly == '0) begin
                    vref_q <= 1'b1;
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    busy_q <= 1'b1;
                    cnt_q  <= dly;
                end
            end else if (busy_q) begin
                cnt_q <= cnt_q - PH_W'(1);
                if (cnt_q == PH_W'(1)) begin
                    vref_q <= 1'b1;
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign vref_o = vref_q;

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> ((cnt_q != '0) && (int'(cnt_q) < PERIOD_CNT)));
    // R5
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !ref_stb) |=> (cnt_q == $past(cnt_q) - PH_W'(1)));
endmodule

// File: rtl/pbo_refgen.sv
// Top of the phase build-out reference generator. It combines the enables and
// wires the meter, the clear filter, the offset store and the retimer.
// All inputs are synchronous to clk.
module pbo_refgen
    import pbo_pkg::*;
#(
    parameter int PERIOD_CNT  = 12500,
    parameter int FRAME_CNT   = 12500,
    parameter int CLR_LOW_MIN = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_stb,
    input  logic              fb_stb,
    input  logic              en_pin,
    input  logic              auto_en,
    input  logic              hold_ret,
    input  logic              mode_stb,
    input  logic              clr_n,
    output logic              vref_stb,
    output logic [OFF_W-1:0]  offset_o,
    output logic              build_en_o
);
    logic     en_eff;
    logic     clr_hit;
    pbo_off_t meas;
    pbo_off_t applied;

    // Effective enable: manual, or automatic unless vetoed after holdover.
    assign en_eff = en_pin | (auto_en & ~hold_ret);

    pbo_phase_meter #(.PERIOD_CNT(PERIOD_CNT)) u_meter (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb), .meas_o(meas)
    );

    pbo_clear_filter #(.CLR_LOW_MIN(CLR_LOW_MIN)) u_clr (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .clr_hit_o(clr_hit)
    );

    pbo_offset_store #(.FRAME_CNT(FRAME_CNT)) u_store (
        .clk(clk), .rst_n(rst_n), .en_eff(en_eff), .mode_stb(mode_stb),
        .clr_hit(clr_hit), .meas_i(meas), .applied_o(applied)
    );

    pbo_retimer #(.PERIOD_CNT(PERIOD_CNT)) u_retime (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .applied_i(applied), .vref_o(vref_stb)
    );

    assign offset_o   = applied;
    assign build_en_o = en_eff;

    // R4
    no_capture_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_eff && mode_stb && !clr_hit && (applied == '0)) |=> (applied == '0));
endmodule

// File: tb/tb_pbo_refgen.sv
module tb_pbo_refgen;
    localparam int P   = 64;
    localparam int FR  = 50;
    localparam int CLR = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_stb = 1'b0, fb_stb = 1'b0, en_pin = 1'b0, auto_en = 1'b0;
    logic hold_ret = 1'b0, mode_stb = 1'b0, clr_n = 1'b1;
    logic vref_stb, build_en_o;
    logic [15:0] offset_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pbo_refgen #(.PERIOD_CNT(P), .FRAME_CNT(FR), .CLR_LOW_MIN(CLR)) dut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
        .en_pin(en_pin), .auto_en(auto_en), .hold_ret(hold_ret),
        .mode_stb(mode_stb), .clr_n(clr_n), .vref_stb(vref_stb),
        .offset_o(offset_o), .build_en_o(build_en_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int off();
        return int'($signed(offset_o));
    endfunction

    task automatic measure(input int k);
        @(negedge clk); ref_stb = 1'b1; fb_stb = (k == 0);
        @(negedge clk); ref_stb = 1'b0; fb_stb = 1'b0;
        if (k > 0) begin
            repeat (k - 1) @(negedge clk);
            fb_stb = 1'b1;
            @(negedge clk); fb_stb = 1'b0;
        end
    endtask

    task automatic capture();
        @(negedge clk); mode_stb = 1'b1;
        @(negedge clk); mode_stb = 1'b0;
    endtask

    task automatic vref_delay(output int first, output int pulses);
        repeat (P + 2) @(negedge clk);
        ref_stb = 1'b1;
        @(negedge clk); ref_stb = 1'b0;
        first = -1; pulses = 0;
        for (int i = 0; i < P + 4; i++) begin
            if (vref_stb) begin
                if (first < 0) first = i;
                pulses++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R11 offset", off(), 0);
        chk("R11 vref", int'(vref_stb), 0);
        chk("R11 build_en", int'(build_en_o), 0);
    endtask

    task automatic t_enable();
        @(negedge clk); en_pin = 1; auto_en = 0; hold_ret = 0; #1;
        chk("R1 pin", int'(build_en_o), 1);
        en_pin = 0; auto_en = 1; #1;
        chk("R1 auto", int'(build_en_o), 1);
        hold_ret = 1; #1;
        chk("R1 veto", int'(build_en_o), 0);
        en_pin = 1; #1;
        chk("R1 pin over veto", int'(build_en_o), 1);
        auto_en = 0; hold_ret = 0;
    endtask

    task automatic t_measure();
        measure(10); capture(); chk("R2 R3 +10", off(), 10);
        measure(50); capture(); chk("R2 wrap -14", off(), -14);
        measure(0);  capture(); chk("R2 coincident", off(), 0);
        measure(32); capture(); chk("R2 half", off(), 32);
        measure(33); capture(); chk("R2 half+1", off(), -31);
    endtask

    task automatic t_retime();
        int f, n;
        measure(10); capture();
        vref_delay(f, n);
        chk("R5 delay 10", f, 10); chk("R5 one pulse", n, 1);
        measure(0); capture();
        vref_delay(f, n);
        chk("R5 delay 0", f, 0); chk("R5 one pulse d0", n, 1);
        measure(50); capture();
        vref_delay(f, n);
        chk("R6 delay neg", f, 50); chk("R6 one pulse", n, 1);
    endtask

    task automatic t_capture_off();
        measure(10); capture(); chk("R3 setup", off(), 10);
        @(negedge clk); en_pin = 0;
        measure(5); capture(); chk("R4 disabled", off(), 10);
        @(negedge clk); hold_ret = 1; auto_en = 1;
        measure(6); capture(); chk("R4 vetoed", off(), 10);
        @(negedge clk); hold_ret = 0;
        measure(5); capture(); chk("R1 R3 auto capture", off(), 5);
        @(negedge clk); en_pin = 1; auto_en = 0;
    endtask

    task automatic t_slew();
        measure(4); capture();
        repeat (3 * FR) @(negedge clk);
        chk("R10 hold", off(), 4);
        @(negedge clk); en_pin = 0;
        repeat (FR - 1) @(negedge clk);
        chk("R9 before step", off(), 4);
        @(negedge clk);
        chk("R9 first step", off(), 3);
        repeat (3 * FR) @(negedge clk);
        chk("R9 reach zero", off(), 0);
        repeat (2 * FR) @(negedge clk);
        chk("R9 stay zero", off(), 0);
        @(negedge clk); en_pin = 1;
        measure(60); capture(); chk("R2 -4", off(), -4);
        @(negedge clk); en_pin = 0;
        repeat (FR) @(negedge clk);
        chk("R9 neg step", off(), -3);
        repeat (3 * FR) @(negedge clk);
        chk("R9 neg zero", off(), 0);
        @(negedge clk); en_pin = 1;
    endtask

    task automatic t_clear();
        measure(10); capture();
        @(negedge clk); clr_n = 0;
        repeat (CLR - 1) @(negedge clk);
        clr_n = 1;
        repeat (3) @(negedge clk);
        chk("R7 short ignored", off(), 10);
        clr_n = 0;
        repeat (CLR) @(negedge clk);
        clr_n = 1;
        @(negedge clk);
        chk("R7 clear", off(), 0);
    endtask

    task automatic t_clear_vs_capture();
        measure(10); capture();
        measure(7);
        @(negedge clk); clr_n = 0;
        repeat (35) @(negedge clk);
        mode_stb = 1;
        @(negedge clk); mode_stb = 0;
        repeat (4) @(negedge clk);
        clr_n = 1;
        @(negedge clk);
        chk("R8 clear beats capture", off(), 0);
        capture();
        chk("R8 capture after clear", off(), 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_measure();
        t_retime();
        t_capture_off();
        t_slew();
        t_clear();
        t_clear_vs_capture();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule